// File: doc/BRIEF.md
# Sparse Token-Passing Event Readout

This block collects digitised hit events from a bank of channels and serialises them, one event at a time, onto a pair of serial data lines. Each channel owns a small FIFO. A capture port writes one event per cycle into the addressed channel. The event carries a threshold bit, an amplitude, a fine time and the bunch-crossing timestamp current at the capture edge. The timestamp comes from an internal Gray-code counter that advances on a bunch-crossing tick.

A token visits only channels whose FIFO holds data. It starts at the channel after the one served last and wraps around the bank. The served event is popped and formed into a 38-bit word. Half of the word is shifted out on each line, either one bit per clock or one bit per clock phase. When nothing is pending, the first line rests high, which serves as the empty indication. Writes to a full FIFO are dropped and counted.

Top module: `evt_token_readout`

## Requirements
- R1: The event word, bit 37 down to bit 0, is {flag=1, threshold, channel[5:0], amplitude[9:0], time[7:0], timestamp[11:0]}. dataOut1 carries bits 37..19 and dataOut2 carries bits 18..0, each most significant bit first.
- R2: In single-rate mode a frame lasts 19 cycles and shows one bit per cycle on each line. It is preceded by exactly one idle cycle in which dataOut1 and dataOut2 are both 0.
- R3: In dual-rate mode a frame lasts 10 cycles. The high clock phase shows the earlier bit of a pair and the low phase shows the later bit. The low phase of the tenth cycle shows 0 on both lines.
- R4: When no frame is being shifted and every channel FIFO is empty, dataOut1 is 1 and dataOut2 is 0.
- R5: Each channel FIFO holds 4 events, and the events of one channel are read out in capture order.
- R6: A capture into a full channel is dropped and leaves that channel's stored events unchanged. ovfCount counts dropped captures and saturates at 255.
- R7: A frame is served from the first channel holding data, searching upward from the channel after the one served last and wrapping from 63 to 0. After reset the search starts at channel 0.
- R8: The timestamp stored with an event is the Gray code of the number of bcTick cycles seen since reset, counted before the capture edge. A tick on the same edge as the capture is not yet included.
- R9: After reset all FIFOs are empty, ovfCount is 0, the timestamp count is 0 and dataOut1 is 1.
- R10: ddrMode is sampled when a frame is loaded. A change of ddrMode during a frame affects only later frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout and token clock |
| rstN | input | 1 | Active-low synchronous reset |
| bcTick | input | 1 | Bunch-crossing advance for the timestamp counter |
| ddrMode | input | 1 | 1: two bits per cycle per line, 0: one bit per cycle |
| hitValid | input | 1 | Capture strobe |
| hitChan | input | 6 | Channel addressed by the capture |
| hitThr | input | 1 | Threshold bit of the captured event |
| hitAmp | input | 10 | Amplitude of the captured event |
| hitTime | input | 8 | Fine time of the captured event |
| dataOut1 | output | 1 | Serial line for the upper half word; empty flag when idle |
| dataOut2 | output | 1 | Serial line for the lower half word |
| ovfCount | output | 8 | Saturating count of dropped captures |

## Verification
A corrupted FIFO pointer or count shows up in the next frame from that channel. That frame carries a stale or reordered amplitude, or a frame appears or goes missing, within about 20 cycles of the load. A wrong last-served register changes the channel field and order of the following frames as soon as two channels are pending together. A wrong shift count or latched mode breaks the framing at the very next idle cycle. The directed scenarios therefore compare whole words, frame order, idle levels and the overflow count right after each frame.

// File: rtl/evtro_pkg.sv
package evtro_pkg;
  // Strobes from the readout control to the datapath
  typedef struct packed {
    logic load;   // pop granted channel and load shifters
    logic shift;  // advance shifters
    logic ddr;    // latched dual-rate mode of current frame
  } evtroStrb_t;
endpackage

// File: rtl/evtro_ctrl.sv
module evtro_ctrl
  import evtro_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int HALF_W = 19,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(HALF_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ddrMode,
  input  logic [NUM_CH-1:0] pendVec,
  output evtroStrb_t        strb,
  output logic [CH_W-1:0]   grantIdx,
  output logic              busy
);
  localparam int SDR_STEPS = HALF_W;
  localparam int DDR_STEPS = (HALF_W + 1) / 2;

  typedef enum logic {ST_IDLE, ST_SHIFT} state_t;
  state_t state;
  logic [CNT_W-1:0] stepCnt;
  logic [CH_W-1:0] lastSrv;
  logic ddrQ;
  logic anyPend;
  logic [CH_W-1:0] pick;

  assign anyPend = |pendVec;

  // Round-robin search starting after the last served channel
  always_comb begin
    logic found;
    found = 1'b0;
    pick = '0;
    for (int off = 1; off <= NUM_CH; off++) begin
      int idx;
      idx = (int'(lastSrv) + off) % NUM_CH;
      if (!found && pendVec[idx]) begin
        found = 1'b1;
        pick = CH_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      stepCnt <= '0;
      lastSrv <= CH_W'(NUM_CH - 1);
      ddrQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (anyPend) begin
          state <= ST_SHIFT;
          ddrQ <= ddrMode;
          lastSrv <= pick;
          stepCnt <= ddrMode ? CNT_W'(DDR_STEPS - 1) : CNT_W'(SDR_STEPS - 1);
        end
        ST_SHIFT: begin
          if (stepCnt == '0) state <= ST_IDLE;
          else stepCnt <= stepCnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strb.load = (state == ST_IDLE) && anyPend;
  assign strb.shift = (state == ST_SHIFT);
  assign strb.ddr = ddrQ;
  assign grantIdx = pick;
  assign busy = (state == ST_SHIFT);

  // R7: a load only ever pops a channel that holds data
  a_r7_grant_pending: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> pendVec[grantIdx]);

  // R2/R3: the step counter stays inside one frame
  a_r2_frame_len: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (stepCnt < CNT_W'(SDR_STEPS)));

  // R10: the frame mode is held for the whole frame
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.load && stepCnt != '0) |=> $stable(ddrQ));
endmodule

// File: rtl/evtro_dpath.sv
module evtro_dpath
  import evtro_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int AMP_W = 10,
  parameter int TIME_W = 8,
  parameter int BC_W = 12,
  parameter int OVF_W = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int WORD_W = 2 + CH_W + AMP_W + TIME_W + BC_W,
  localparam int HALF_W = (WORD_W + 1) / 2,
  localparam int PAD_W = 2 * HALF_W,
  localparam int ENTRY_W = 1 + AMP_W + TIME_W + BC_W,
  localparam int PTR_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bcTick,
  input  logic              hitValid,
  input  logic [CH_W-1:0]   hitChan,
  input  logic              hitThr,
  input  logic [AMP_W-1:0]  hitAmp,
  input  logic [TIME_W-1:0] hitTime,
  input  evtroStrb_t        strb,
  input  logic [CH_W-1:0]   grantIdx,
  input  logic              busy,
  output logic [NUM_CH-1:0] pendVec,
  output logic              dataOut1,
  output logic              dataOut2,
  output logic [OVF_W-1:0]  ovfCount
);
  // Bunch-crossing timestamp: binary count with Gray-coded copy
  logic [BC_W-1:0] bcBin, bcGray, bcNext;
  logic pastValid;
  assign bcNext = bcBin + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bcBin <= '0;
      bcGray <= '0;
      pastValid <= 1'b0;
    end else begin
      pastValid <= 1'b1;
      if (bcTick) begin
        bcBin <= bcNext;
        bcGray <= bcNext ^ (bcNext >> 1);
      end
    end
  end

  // R8: one tick changes exactly one timestamp bit
  a_r8_gray_step: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(bcTick)) |-> ($countones(bcGray ^ $past(bcGray)) == 1));

  logic [ENTRY_W-1:0] capEntry;
  assign capEntry = {hitThr, hitAmp, hitTime, bcGray};

  logic [ENTRY_W-1:0] headData [NUM_CH];
  logic [NUM_CH-1:0] fullVec;

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [ENTRY_W-1:0] mem [FIFO_DEPTH];
    logic [PTR_W-1:0] wrPtr, rdPtr;
    logic [CNT_W-1:0] fill;
    logic wrReq, wrEn, rdEn;

    assign wrReq = hitValid && (hitChan == CH_W'(g));
    assign wrEn = wrReq && !fullVec[g];
    assign rdEn = strb.load && (grantIdx == CH_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        fill <= '0;
      end else begin
        if (wrEn) begin
          mem[wrPtr] <= capEntry;
          wrPtr <= (wrPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (rdEn)
          rdPtr <= (rdPtr == PTR_W'(FIFO_DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        if (wrEn && !rdEn) fill <= fill + 1'b1;
        else if (rdEn && !wrEn) fill <= fill - 1'b1;
      end
    end

    assign headData[g] = mem[rdPtr];
    assign pendVec[g] = (fill != '0);
    assign fullVec[g] = (fill == CNT_W'(FIFO_DEPTH));

    // R5: occupancy never exceeds the FIFO depth
    a_r5_depth_bound: assert property (@(posedge clk) disable iff (!rstN)
      fill <= CNT_W'(FIFO_DEPTH));

    // R6: a dropped capture does not grow the channel
    a_r6_drop_no_grow: assert property (@(posedge clk) disable iff (!rstN)
      (wrReq && fill == CNT_W'(FIFO_DEPTH) && !rdEn) |=> (fill == CNT_W'(FIFO_DEPTH)));
  end

  // Overflow count of dropped captures, saturating
  always_ff @(posedge clk) begin
    if (!rstN) ovfCount <= '0;
    else if (hitValid && fullVec[hitChan] && ovfCount != '1)
      ovfCount <= ovfCount + 1'b1;
  end

  // Word assembly and two-line shifters
  logic [ENTRY_W-1:0] head;
  logic [WORD_W-1:0] word;
  logic [PAD_W-1:0] padded;
  logic [HALF_W:0] sh1, sh2;

  assign head = headData[grantIdx];
  assign word = {1'b1, head[ENTRY_W-1], grantIdx, head[ENTRY_W-2:0]};
  assign padded = PAD_W'(word) << (PAD_W - WORD_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sh1 <= '0;
      sh2 <= '0;
    end else if (strb.load) begin
      sh1 <= {padded[PAD_W-1:HALF_W], 1'b0};
      sh2 <= {padded[HALF_W-1:0], 1'b0};
    end else if (strb.shift) begin
      sh1 <= strb.ddr ? (sh1 << 2) : (sh1 << 1);
      sh2 <= strb.ddr ? (sh2 << 2) : (sh2 << 1);
    end
  end

  logic lowPhase;
  assign lowPhase = strb.ddr && !clk;
  assign dataOut1 = busy ? (lowPhase ? sh1[HALF_W-1] : sh1[HALF_W]) : ~|pendVec;
  assign dataOut2 = busy ? (lowPhase ? sh2[HALF_W-1] : sh2[HALF_W]) : 1'b0;
endmodule

// File: rtl/evt_token_readout.sv
module evt_token_readout
  import evtro_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int FIFO_DEPTH = 4,
  parameter int AMP_W = 10,
  parameter int TIME_W = 8,
  parameter int BC_W = 12,
  parameter int OVF_W = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int WORD_W = 2 + CH_W + AMP_W + TIME_W + BC_W,
  localparam int HALF_W = (WORD_W + 1) / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bcTick,
  input  logic              ddrMode,
  input  logic              hitValid,
  input  logic [CH_W-1:0]   hitChan,
  input  logic              hitThr,
  input  logic [AMP_W-1:0]  hitAmp,
  input  logic [TIME_W-1:0] hitTime,
  output logic              dataOut1,
  output logic              dataOut2,
  output logic [OVF_W-1:0]  ovfCount
);
  evtroStrb_t strb;
  logic [CH_W-1:0] grantIdx;
  logic [NUM_CH-1:0] pendVec;
  logic busy;

  evtro_ctrl #(.NUM_CH(NUM_CH), .HALF_W(HALF_W)) uCtrl (
    .clk(clk), .rstN(rstN), .ddrMode(ddrMode), .pendVec(pendVec),
    .strb(strb), .grantIdx(grantIdx), .busy(busy)
  );

  evtro_dpath #(
    .NUM_CH(NUM_CH), .FIFO_DEPTH(FIFO_DEPTH), .AMP_W(AMP_W),
    .TIME_W(TIME_W), .BC_W(BC_W), .OVF_W(OVF_W)
  ) uDpath (
    .clk(clk), .rstN(rstN), .bcTick(bcTick), .hitValid(hitValid),
    .hitChan(hitChan), .hitThr(hitThr), .hitAmp(hitAmp), .hitTime(hitTime),
    .strb(strb), .grantIdx(grantIdx), .busy(busy), .pendVec(pendVec),
    .dataOut1(dataOut1), .dataOut2(dataOut2), .ovfCount(ovfCount)
  );
endmodule

// File: tb/tb_evt_token_readout.sv
module tb_evt_token_readout;
  logic clk = 1'b0;
  logic rstN, bcTick, ddrMode, hitValid, hitThr;
  logic [5:0] hitChan;
  logic [9:0] hitAmp;
  logic [7:0] hitTime;
  logic dataOut1, dataOut2;
  logic [7:0] ovfCount;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  evt_token_readout dut (
    .clk(clk), .rstN(rstN), .bcTick(bcTick), .ddrMode(ddrMode),
    .hitValid(hitValid), .hitChan(hitChan), .hitThr(hitThr),
    .hitAmp(hitAmp), .hitTime(hitTime), .dataOut1(dataOut1),
    .dataOut2(dataOut2), .ovfCount(ovfCount)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [37:0] mkWord(int ch, bit thr, int amp, int tim, int bc);
    return {1'b1, thr, 6'(ch), 10'(amp), 8'(tim), 12'(bc)};
  endfunction

  function automatic logic [11:0] toGray(int n);
    return 12'(n ^ (n >> 1));
  endfunction

  // all tasks leave time at posedge+1
  task automatic doReset();
    rstN = 0; bcTick = 0; ddrMode = 0; hitValid = 0;
    hitChan = 0; hitThr = 0; hitAmp = 0; hitTime = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
  endtask

  task automatic capture(input int ch, input bit thr, input int amp, input int tim);
    hitValid = 1; hitChan = 6'(ch); hitThr = thr; hitAmp = 10'(amp); hitTime = 8'(tim);
    @(posedge clk); #1;
    hitValid = 0;
  endtask

  task automatic readFrame(input bit ddr, output logic [37:0] w, output bit padOk);
    int waitCyc = 0;
    w = '0; padOk = 1;
    while (dataOut1 !== 1'b0 && waitCyc < 5000) begin
      @(posedge clk); #1;
      waitCyc++;
    end
    if (waitCyc >= 5000) check(0, "R2 frame never started", 0, 0);
    // gap cycle: both lines low (R2)
    check(dataOut2 === 1'b0, "R2 gap line2", dataOut2, 0);
    if (!ddr) begin
      for (int i = 0; i < 19; i++) begin
        @(posedge clk); #1;
        w[37 - i] = dataOut1;
        w[18 - i] = dataOut2;
      end
    end else begin
      for (int i = 0; i < 10; i++) begin
        @(posedge clk); #1;
        w[37 - 2 * i] = dataOut1;
        w[18 - 2 * i] = dataOut2;
        #2;
        if (i < 9) begin
          w[36 - 2 * i] = dataOut1;
          w[17 - 2 * i] = dataOut2;
        end else if (dataOut1 !== 1'b0 || dataOut2 !== 1'b0) padOk = 0;
      end
    end
    @(posedge clk); #1;
  endtask

  task automatic waitEmpty();
    int run = 0;
    int cyc = 0;
    while (run < 22 && cyc < 20000) begin
      @(posedge clk); #1;
      cyc++;
      if (dataOut1 === 1'b1 && dataOut2 === 1'b0) run++; else run = 0;
    end
  endtask

  task automatic t_reset();
    doReset();
    check(dataOut1 === 1'b1, "R9 reset line1 empty", dataOut1, 1);
    check(dataOut2 === 1'b0, "R4 reset line2 low", dataOut2, 0);
    check(ovfCount === 8'd0, "R9 reset ovfCount", ovfCount, 0);
  endtask

  task automatic t_single_sdr();
    logic [37:0] w; bit p;
    doReset();
    capture(37, 1, 'h2A5, 'h9C);
    readFrame(0, w, p);
    check(w === mkWord(37, 1, 'h2A5, 'h9C, 0), "R1 R2 sdr word", w, mkWord(37, 1, 'h2A5, 'h9C, 0));
    check(dataOut1 === 1'b1 && dataOut2 === 1'b0, "R4 idle after frame", {dataOut1, dataOut2}, 2'b10);
  endtask

  task automatic t_ddr();
    logic [37:0] w; bit p;
    doReset();
    ddrMode = 1;
    capture(22, 0, 'h15A, 'h63);
    readFrame(1, w, p);
    check(w === mkWord(22, 0, 'h15A, 'h63, 0), "R3 ddr word", w, mkWord(22, 0, 'h15A, 'h63, 0));
    check(p, "R3 ddr pad phase zero", p, 1);
    check(dataOut1 === 1'b1, "R4 idle after ddr frame", dataOut1, 1);
    ddrMode = 0;
  endtask

  task automatic t_arb();
    logic [37:0] w [4];
    logic [37:0] e [4];
    doReset();
    e[0] = mkWord(10, 0, 101, 1, 0);
    e[1] = mkWord(40, 1, 104, 4, 0);
    e[2] = mkWord(3, 0, 102, 2, 0);
    e[3] = mkWord(10, 1, 103, 3, 0);
    fork
      begin
        capture(10, 0, 101, 1);
        capture(3, 0, 102, 2);
        capture(40, 1, 104, 4);
        capture(10, 1, 103, 3);
      end
      begin
        for (int k = 0; k < 4; k++) begin
          bit p;
          readFrame(0, w[k], p);
        end
      end
    join
    for (int k = 0; k < 4; k++)
      check(w[k] === e[k], $sformatf("R7 round-robin frame %0d", k), w[k], e[k]);
  endtask

  task automatic t_fifo_ovf();
    logic [37:0] w [5];
    doReset();
    fork
      begin
        for (int k = 0; k < 6; k++) capture(7, 0, 200 + k, k);
      end
      begin
        for (int k = 0; k < 5; k++) begin
          bit p;
          readFrame(0, w[k], p);
        end
      end
    join
    for (int k = 0; k < 5; k++)
      check(w[k] === mkWord(7, 0, 200 + k, k, 0), $sformatf("R5 fifo order %0d", k), w[k], mkWord(7, 0, 200 + k, k, 0));
    waitEmpty();
    check(dataOut1 === 1'b1, "R6 dropped event not sent", dataOut1, 1);
    check(ovfCount === 8'd1, "R6 one drop counted", ovfCount, 1);
  endtask

  task automatic t_saturate();
    doReset();
    for (int k = 0; k < 300; k++) capture(9, 0, k, 0);
    waitEmpty();
    check(ovfCount === 8'd255, "R6 ovfCount saturates", ovfCount, 255);
  endtask

  task automatic t_gray();
    logic [37:0] w; bit p;
    doReset();
    bcTick = 1;
    repeat (5) @(posedge clk);
    #1 bcTick = 0;
    capture(0, 0, 5, 5);
    readFrame(0, w, p);
    check(w === mkWord(0, 0, 5, 5, toGray(5)), "R8 gray after 5 ticks", w, mkWord(0, 0, 5, 5, toGray(5)));
    bcTick = 1;
    repeat (300) @(posedge clk);
    #1;
    capture(33, 1, 7, 7);  // tick still high on the capture edge
    bcTick = 0;
    readFrame(0, w, p);
    check(w === mkWord(33, 1, 7, 7, toGray(305)), "R8 gray with same-edge tick", w, mkWord(33, 1, 7, 7, toGray(305)));
  endtask

  task automatic t_mode_switch();
    logic [37:0] w0, w1;
    doReset();
    fork
      begin
        capture(1, 0, 11, 1);
        capture(2, 1, 22, 2);
      end
      begin
        repeat (6) @(posedge clk);
        #1 ddrMode = 1;
      end
      begin
        bit p;
        readFrame(0, w0, p);
        readFrame(1, w1, p);
      end
    join
    check(w0 === mkWord(1, 0, 11, 1, 0), "R10 frame keeps sdr", w0, mkWord(1, 0, 11, 1, 0));
    check(w1 === mkWord(2, 1, 22, 2, 0), "R10 next frame ddr", w1, mkWord(2, 1, 22, 2, 0));
    ddrMode = 0;
  endtask

  initial begin
    t_reset();
    t_single_sdr();
    t_ddr();
    t_arb();
    t_fifo_ovf();
    t_gray();
    t_mode_switch();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule